// File: doc/BRIEF.md
# Low Pin Count I/O Target

This block is the target side of a Low Pin Count bus port. It watches the 4-bit multiplexed nibble bus and the active-low frame strobe on every bus clock. It decodes single-byte I/O read and I/O write cycles whose 16-bit address lands in a parameterised window. Claimed cycles are forwarded to a byte-wide register file. Read data is returned to the host behind wait and ready SYNC nibbles.

Any cycle type other than a 1-byte I/O read or write is dropped without driving the bus. A cycle aimed outside the window is dropped in the same way. The host can abort at any point by pulling the frame strobe low. A park input holds the interface idle and silent while the bus side is being powered down.

Top module: `lpc_io_target`

## Requirements
- R1: While `rst_ni` is low, and on the first clock after it rises, `bus_oe_o`, `reg_we_o` and `reg_re_o` are all 0.
- R2: A cycle starts only when the nibble is 0000 on the last clock that `frm_ni` is low. A frame whose last low clock carries any other nibble is ignored, and the bus is not driven.
- R3: The nibble after the start gives the cycle type: 0000 is I/O read and 0010 is I/O write. Any other type value makes the target ignore the cycle, and it never drives the bus during it.
- R4: The address arrives as four nibbles, most significant first. The cycle is claimed only if BASE_ADDR <= address < BASE_ADDR+WIN_SIZE, and `reg_addr_o` then equals address-BASE_ADDR. A cycle outside the window is never driven and produces no strobe.
- R5: In a write, the two data nibbles come low nibble first and are followed by a 2-clock host turnaround. `reg_we_o` then pulses for exactly one clock during the first SYNC clock, with the byte on `reg_wdata_o`.
- R6: After the host turnaround the target drives 0101 for exactly WAIT_CLKS clocks (WAIT_CLKS >= 1), followed by 0000 for one clock.
- R7: In a read, `reg_re_o` pulses for one clock during the first SYNC clock. The byte presented on `reg_rdata_i` on the following clock is driven after the ready SYNC, low nibble first, then the high nibble.
- R8: After the last target-driven nibble, the target drives 1111 for one clock, then releases the bus (`bus_oe_o`=0).
- R9: When `frm_ni` is sampled low, `bus_oe_o` is 0 from the next clock on, and the parser starts over. An aborted write never reaches the register file.
- R10: While `park_i` is high, the bus is not driven, no strobe is issued and no cycle starts. Normal cycles resume after `park_i` falls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bus clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| frm_ni | input | 1 | Active-low frame strobe from the host |
| park_i | input | 1 | Power-down park request |
| bus_nib_i | input | 4 | Nibble sampled from the shared bus |
| bus_nib_o | output | 4 | Nibble the target drives |
| bus_oe_o | output | 1 | Target output enable for the bus |
| reg_addr_o | output | OFS_W | Offset of the access inside the window |
| reg_we_o | output | 1 | One-clock write strobe |
| reg_wdata_o | output | 8 | Write byte |
| reg_re_o | output | 1 | One-clock read strobe |
| reg_rdata_i | input | 8 | Read byte, valid the clock after `reg_re_o` |

## Verification
The bench builds the target with BASE_ADDR=16'h1230, WIN_SIZE=8 and WAIT_CLKS=3. The small window puts both edges, 0x1230 and 0x1237, and both near misses, 0x122F and 0x1238, within a few directed cycles. The three-clock wait shows that the SYNC stretch follows the parameter rather than a fixed count. Because the wait is longer than one clock, the read byte must be held from the strobe until the ready SYNC.

// File: rtl/lpc_tgt_pkg.sv
package lpc_tgt_pkg;
  typedef enum logic [3:0] {
    S_IDLE, S_CTYPE, S_ADDR, S_WDATA, S_HTAR,
    S_SYNCW, S_READY, S_RDATA, S_TTAR, S_IGNORE
  } lpc_state_e;

  localparam logic [3:0] NIB_START = 4'h0;
  localparam logic [3:0] TYP_IORD  = 4'h0;
  localparam logic [3:0] TYP_IOWR  = 4'h2;
  localparam logic [3:0] SYNC_WAIT = 4'h5;
  localparam logic [3:0] SYNC_RDY  = 4'h0;
  localparam logic [3:0] NIB_TAR   = 4'hF;
endpackage

// File: rtl/lpc_tgt_addr_dec.sv
module lpc_tgt_addr_dec #(
  parameter logic [15:0] BASE  = 16'h0300,
  parameter int unsigned SIZE  = 16,
  parameter int unsigned OFS_W = 4
) (
  input  logic [15:0]      addr_i,
  output logic             hit_o,
  output logic [OFS_W-1:0] ofs_o
);
  // addresses below BASE wrap to >= 2^16 and fail the compare
  logic [16:0] diff;
  assign diff  = {1'b0, addr_i} - {1'b0, BASE};
  assign hit_o = diff < 17'(SIZE);
  assign ofs_o = diff[OFS_W-1:0];
endmodule

// File: rtl/lpc_tgt_drv.sv
module lpc_tgt_drv
  import lpc_tgt_pkg::*;
(
  input  lpc_state_e state_i,
  input  logic [7:0] rdata_i,
  input  logic       hi_i,
  output logic [3:0] nib_o,
  output logic       oe_o
);
  always_comb begin
    oe_o  = 1'b1;
    nib_o = NIB_TAR;
    unique case (state_i)
      S_SYNCW: nib_o = SYNC_WAIT;
      S_READY: nib_o = SYNC_RDY;
      S_RDATA: nib_o = hi_i ? rdata_i[7:4] : rdata_i[3:0];
      S_TTAR:  nib_o = NIB_TAR;
      default: begin
        oe_o  = 1'b0;
        nib_o = 4'h0;
      end
    endcase
  end
endmodule

// File: rtl/lpc_tgt_fsm.sv
module lpc_tgt_fsm
  import lpc_tgt_pkg::*;
#(
  parameter int unsigned WAIT_CLKS = 1,
  parameter int unsigned OFS_W     = 4,
  localparam int unsigned WCW      = (WAIT_CLKS > 1) ? $clog2(WAIT_CLKS) : 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             frm_ni,
  input  logic             park_i,
  input  logic [3:0]       nib_i,
  input  logic             hit_i,
  input  logic [OFS_W-1:0] ofs_i,
  output logic [15:0]      addr_nxt_o,
  output lpc_state_e       state_o,
  output logic             hi_o,
  output logic [7:0]       rdata_o,
  output logic [OFS_W-1:0] reg_addr_o,
  output logic             reg_we_o,
  output logic [7:0]       reg_wdata_o,
  output logic             reg_re_o,
  input  logic [7:0]       reg_rdata_i
);
  localparam logic [WCW-1:0] WLAST = WCW'(WAIT_CLKS - 1);

  lpc_state_e       state_q;
  logic [1:0]       cnt_q;
  logic [WCW-1:0]   wcnt_q;
  logic             is_wr_q;
  logic [15:0]      addr_q;
  logic [OFS_W-1:0] ofs_q;
  logic [7:0]       wdata_q, rdata_q;
  logic             acc;

  assign addr_nxt_o = {addr_q[11:0], nib_i};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= S_IDLE;
      cnt_q   <= '0;
      wcnt_q  <= '0;
      is_wr_q <= 1'b0;
      addr_q  <= '0;
      ofs_q   <= '0;
      wdata_q <= '0;
      rdata_q <= '0;
    end else if (park_i) begin
      state_q <= S_IDLE;
    end else if (!frm_ni) begin
      // last low clock decides; anything but a start code drops the frame
      state_q <= (nib_i == NIB_START) ? S_CTYPE : S_IDLE;
      cnt_q   <= '0;
    end else begin
      unique case (state_q)
        S_CTYPE: begin
          cnt_q <= '0;
          if (nib_i == TYP_IORD) begin
            is_wr_q <= 1'b0;
            state_q <= S_ADDR;
          end else if (nib_i == TYP_IOWR) begin
            is_wr_q <= 1'b1;
            state_q <= S_ADDR;
          end else begin
            state_q <= S_IGNORE;
          end
        end
        S_ADDR: begin
          addr_q <= addr_nxt_o;
          cnt_q  <= cnt_q + 2'd1;
          if (cnt_q == 2'd3) begin
            cnt_q <= '0;
            ofs_q <= ofs_i;
            if (!hit_i)       state_q <= S_IGNORE;
            else if (is_wr_q) state_q <= S_WDATA;
            else              state_q <= S_HTAR;
          end
        end
        S_WDATA: begin
          if (cnt_q[0] == 1'b0) begin
            wdata_q[3:0] <= nib_i;
            cnt_q        <= 2'd1;
          end else begin
            wdata_q[7:4] <= nib_i;
            cnt_q        <= '0;
            state_q      <= S_HTAR;
          end
        end
        S_HTAR: begin
          if (cnt_q[0] == 1'b0) begin
            cnt_q <= 2'd1;
          end else begin
            cnt_q   <= '0;
            wcnt_q  <= '0;
            state_q <= S_SYNCW;
          end
        end
        S_SYNCW: begin
          if (wcnt_q == WLAST) state_q <= S_READY;
          else                 wcnt_q  <= wcnt_q + 1'b1;
        end
        S_READY: begin
          if (is_wr_q) begin
            state_q <= S_TTAR;
          end else begin
            rdata_q <= reg_rdata_i;
            cnt_q   <= '0;
            state_q <= S_RDATA;
          end
        end
        S_RDATA: begin
          if (cnt_q[0] == 1'b0) cnt_q <= 2'd1;
          else                  state_q <= S_TTAR;
        end
        S_TTAR:  state_q <= S_IDLE;
        default: state_q <= state_q;
      endcase
    end
  end

  assign acc         = (state_q == S_SYNCW) && (wcnt_q == '0);
  assign reg_we_o    = acc && is_wr_q;
  assign reg_re_o    = acc && !is_wr_q;
  assign reg_addr_o  = ofs_q;
  assign reg_wdata_o = wdata_q;
  assign state_o     = state_q;
  assign hi_o        = cnt_q[0];
  assign rdata_o     = rdata_q;

  AST_READY_AFTER_WAIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == S_READY) |-> ($past(state_q) == S_SYNCW)); // R6
  AST_STROBE_ONCE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_we_o || reg_re_o) |=> !(reg_we_o || reg_re_o)); // R5
  AST_TTAR_ENDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == S_TTAR) |=> (state_q == S_IDLE || state_q == S_CTYPE)); // R8
endmodule

// File: rtl/lpc_io_target.sv
module lpc_io_target
  import lpc_tgt_pkg::*;
#(
  parameter logic [15:0] BASE_ADDR = 16'h0300,
  parameter int unsigned WIN_SIZE  = 16,
  parameter int unsigned WAIT_CLKS = 1,
  localparam int unsigned OFS_W    = (WIN_SIZE > 1) ? $clog2(WIN_SIZE) : 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             frm_ni,
  input  logic             park_i,
  input  logic [3:0]       bus_nib_i,
  output logic [3:0]       bus_nib_o,
  output logic             bus_oe_o,
  output logic [OFS_W-1:0] reg_addr_o,
  output logic             reg_we_o,
  output logic [7:0]       reg_wdata_o,
  output logic             reg_re_o,
  input  logic [7:0]       reg_rdata_i
);
  logic [15:0]      addr_nxt;
  logic             hit;
  logic [OFS_W-1:0] ofs;
  lpc_state_e       state;
  logic             hi;
  logic [7:0]       rdata;

  lpc_tgt_addr_dec #(.BASE(BASE_ADDR), .SIZE(WIN_SIZE), .OFS_W(OFS_W)) u_dec (
    .addr_i(addr_nxt), .hit_o(hit), .ofs_o(ofs)
  );

  lpc_tgt_fsm #(.WAIT_CLKS(WAIT_CLKS), .OFS_W(OFS_W)) u_fsm (
    .clk_i(clk_i), .rst_ni(rst_ni), .frm_ni(frm_ni), .park_i(park_i),
    .nib_i(bus_nib_i), .hit_i(hit), .ofs_i(ofs), .addr_nxt_o(addr_nxt),
    .state_o(state), .hi_o(hi), .rdata_o(rdata),
    .reg_addr_o(reg_addr_o), .reg_we_o(reg_we_o), .reg_wdata_o(reg_wdata_o),
    .reg_re_o(reg_re_o), .reg_rdata_i(reg_rdata_i)
  );

  lpc_tgt_drv u_drv (
    .state_i(state), .rdata_i(rdata), .hi_i(hi), .nib_o(bus_nib_o), .oe_o(bus_oe_o)
  );

  AST_FRAME_RELEASE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !frm_ni |=> !bus_oe_o); // R9
  AST_PARK_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    park_i |=> (!bus_oe_o && !reg_we_o && !reg_re_o)); // R10
endmodule

// File: tb/lpc_io_target_test.sv
module lpc_io_target_test;
  localparam logic [15:0] BASE = 16'h1230;
  localparam int WSZ = 8;
  localparam int WT  = 3;

  logic clk = 0, rst_n = 0, frm_n = 1, park = 0;
  logic [3:0] nib = 4'hF;
  logic [3:0] bus_o;
  logic bus_oe, we, re;
  logic [2:0] raddr;
  logic [7:0] wdata, rdata;
  logic [7:0] mem [WSZ];
  int n_chk = 0, n_bad = 0, oe_cnt = 0, stb_cnt = 0;
  bit done = 0;

  always #10 clk = ~clk;

  lpc_io_target #(.BASE_ADDR(BASE), .WIN_SIZE(WSZ), .WAIT_CLKS(WT)) uut (
    .clk_i(clk), .rst_ni(rst_n), .frm_ni(frm_n), .park_i(park),
    .bus_nib_i(nib), .bus_nib_o(bus_o), .bus_oe_o(bus_oe),
    .reg_addr_o(raddr), .reg_we_o(we), .reg_wdata_o(wdata),
    .reg_re_o(re), .reg_rdata_i(rdata)
  );

  // register file model: sync write, registered read
  initial for (int i = 0; i < WSZ; i++) mem[i] = 8'(i * 17);
  always @(posedge clk) begin
    if (we) mem[raddr] <= wdata;
    if (re) rdata <= mem[raddr];
  end
  always @(negedge clk) begin
    if (bus_oe) oe_cnt++;
    if (we || re) stb_cnt++;
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic cyc(input logic f, input logic [3:0] n);
    frm_n = f; nib = n;
    @(negedge clk);
  endtask

  task automatic hdr(input logic [3:0] typ, input logic [15:0] a);
    cyc(0, 4'h0);
    cyc(1, typ);
    for (int i = 3; i >= 0; i--) cyc(1, a[i*4 +: 4]);
  endtask

  task automatic sync_tail(input string tag);
    for (int k = 0; k < WT; k++) begin
      chk(bus_oe && bus_o == 4'h5, {tag, " R6 wait"}, {bus_oe, bus_o}, 5'h15);
      cyc(1, 4'hF);
    end
    chk(bus_oe && bus_o == 4'h0, {tag, " R6 ready"}, {bus_oe, bus_o}, 5'h10);
    cyc(1, 4'hF);
  endtask

  task automatic do_write(input logic [15:0] a, input logic [7:0] d);
    hdr(4'h2, a);
    cyc(1, d[3:0]); cyc(1, d[7:4]);
    cyc(1, 4'hF); cyc(1, 4'hF);
    chk(we && !re && wdata == d && raddr == 3'(a - BASE), "R5 strobe", {we, wdata}, {1'b1, d});
    sync_tail("R5");
    chk(bus_oe && bus_o == 4'hF, "R8 tar", bus_o, 4'hF);
    cyc(1, 4'hF);
    chk(!bus_oe, "R8 release", bus_oe, 0);
  endtask

  task automatic do_read(input logic [15:0] a, input logic [7:0] exp);
    hdr(4'h0, a);
    cyc(1, 4'hF); cyc(1, 4'hF);
    chk(re && !we && raddr == 3'(a - BASE), "R7 R4 strobe", {re, raddr}, {1'b1, 3'(a - BASE)});
    sync_tail("R7");
    chk(bus_oe && bus_o == exp[3:0], "R7 low", bus_o, exp[3:0]);
    cyc(1, 4'hF);
    chk(bus_oe && bus_o == exp[7:4], "R7 high", bus_o, exp[7:4]);
    cyc(1, 4'hF);
    chk(bus_oe && bus_o == 4'hF, "R8 tar", bus_o, 4'hF);
    cyc(1, 4'hF);
    chk(!bus_oe, "R8 release", bus_oe, 0);
  endtask

  // full-length cycle that must stay silent
  task automatic quiet(input string tag, input logic [3:0] last_start,
                       input logic [3:0] typ, input logic [15:0] a);
    int oe0 = oe_cnt, st0 = stb_cnt;
    cyc(0, 4'h0); cyc(0, last_start);
    cyc(1, typ);
    for (int i = 3; i >= 0; i--) cyc(1, a[i*4 +: 4]);
    for (int i = 0; i < 12; i++) cyc(1, 4'hF);
    chk(oe_cnt == oe0 && stb_cnt == st0, tag, oe_cnt - oe0 + stb_cnt - st0, 0);
  endtask

  task automatic t_reset;
    chk(!bus_oe && !we && !re, "R1 in reset", {bus_oe, we, re}, 0);
    rst_n = 1;
    @(negedge clk);
    chk(!bus_oe && !we && !re, "R1 after reset", {bus_oe, we, re}, 0);
  endtask

  task automatic t_rw;
    do_write(16'h1230, 8'hA5);
    do_write(16'h1237, 8'h3C);
    do_read(16'h1230, 8'hA5);
    do_read(16'h1237, 8'h3C);
    do_read(16'h1233, 8'h33);
  endtask

  task automatic t_miss;
    quiet("R4 miss low", 4'h0, 4'h2, 16'h122F);
    quiet("R4 miss high", 4'h0, 4'h0, 16'h1238);
    quiet("R3 bad type", 4'h0, 4'h8, 16'h1231);
    quiet("R3 type 3", 4'h0, 4'h3, 16'h1231);
    quiet("R2 bad start", 4'h3, 4'h0, 16'h1231);
  endtask

  task automatic t_long_frame;
    cyc(0, 4'h5);
    do_read(16'h1231, 8'h11); // R2: start code on last low clock wins
  endtask

  task automatic t_abort;
    hdr(4'h0, 16'h1234);
    cyc(1, 4'hF); cyc(1, 4'hF);
    cyc(1, 4'hF);
    chk(bus_oe, "R9 driving before abort", bus_oe, 1);
    cyc(0, 4'hF);
    chk(!bus_oe, "R9 released", bus_oe, 1'b0);
    cyc(1, 4'hF);
    cyc(0, 4'h0); cyc(1, 4'h2);
    cyc(1, 4'h1); cyc(1, 4'h2);
    cyc(0, 4'hF); // R9 abort mid-address
    for (int i = 0; i < 4; i++) cyc(1, 4'hF);
    do_read(16'h1232, 8'h22);
  endtask

  task automatic t_park;
    int oe0, st0;
    hdr(4'h0, 16'h1235);
    cyc(1, 4'hF); cyc(1, 4'hF);
    cyc(1, 4'hF);
    park = 1;
    cyc(1, 4'hF);
    chk(!bus_oe, "R10 park releases", bus_oe, 0);
    oe0 = oe_cnt; st0 = stb_cnt;
    do_write_silent(16'h1235, 8'h77);
    chk(oe_cnt == oe0 && stb_cnt == st0, "R10 no cycle", oe_cnt - oe0 + stb_cnt - st0, 0);
    park = 0;
    cyc(1, 4'hF);
    do_read(16'h1235, 8'h55);
  endtask

  task automatic do_write_silent(input logic [15:0] a, input logic [7:0] d);
    hdr(4'h2, a);
    cyc(1, d[3:0]); cyc(1, d[7:4]);
    for (int i = 0; i < 10; i++) cyc(1, 4'hF);
  endtask

  task automatic t_mid_reset;
    hdr(4'h0, 16'h1236);
    cyc(1, 4'hF); cyc(1, 4'hF); cyc(1, 4'hF);
    rst_n = 0;
    #1;
    chk(!bus_oe, "R1 async reset", bus_oe, 0);
    @(negedge clk);
    rst_n = 1;
    cyc(1, 4'hF);
    do_read(16'h1236, 8'h66);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    t_rw();
    t_miss();
    t_long_frame();
    t_abort();
    t_park();
    t_mid_reset();
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog act=hung exp=done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule